// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block sits on the receive byte path of an Ethernet MAC while the MAC is in a low-power wake mode. Software arms it, but only after the receive and transmit paths have both come to a graceful stop. While it is armed, every received frame is dropped and nothing reaches the downstream logic. Meanwhile the block searches each frame for a wake pattern. The pattern is a run of all-ones sync bytes followed by repeated copies of the station's own address.

When a full pattern is seen, the block disarms itself and raises a sticky event bit. The event bit drives an interrupt through a mask. Normal delivery resumes at the next start of frame. The frame that carried the wake pattern is dropped to its end. Checking the FCS of the wake frame and any power control are handled elsewhere.

Top module: `magic_wake_det`

## Requirements
- R1: After reset, `armed_o`, `arm_rej_o`, `event_o` and `irq_o` are all low.
- R2: A cycle with `arm_req_i` high while both `rx_stopped_i` and `tx_stopped_i` are high sets `armed_o` from the next cycle. With either stop input low, `armed_o` is unchanged and `arm_rej_o` is high for exactly the next cycle.
- R3: Any frame whose start-of-frame byte arrives while `armed_o` is high is suppressed in full, and `dlv_valid_o` stays low for all its bytes. A frame that starts with the block disarmed is passed through, with `dlv_valid_o` equal to `rx_valid_i`.
- R4: The wake pattern is SYNC_LEN bytes of 0xFF followed by ADDR_REPS back-to-back copies of the station address, on consecutive valid bytes. The pattern may start at any byte of a frame. Each address copy is sent most significant byte first: `station_addr_i[8*ADDR_BYTES-1 -: 8]` comes first.
- R5: A pattern is detected only while `armed_o` and `rx_enable_i` are both high. The search state is cleared whenever either is low.
- R6: On the clock edge that takes the last pattern byte, `armed_o` falls and `event_o` rises together.
- R7: The search restarts at every start-of-frame byte, so a pattern split across two frames is never detected.
- R8: A byte that breaks the sequence and is not 0xFF resets the search. A breaking 0xFF byte restarts the sync count at one plus the number of 0xFF bytes just before it, capped at SYNC_LEN. A sync run longer than SYNC_LEN is therefore accepted.
- R9: `event_o` stays high until a cycle with `event_clr_i` high, and it clears on the next edge. `irq_o` is `event_o` gated by `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte valid |
| rx_sof_i | input | 1 | Byte is first of a frame |
| rx_eof_i | input | 1 | Byte is last of a frame |
| rx_data_i | input | 8 | Received byte |
| rx_enable_i | input | 1 | Frame reception enabled |
| station_addr_i | input | 8*ADDR_BYTES | Station address |
| rx_stopped_i | input | 1 | Receive path has stopped gracefully |
| tx_stopped_i | input | 1 | Transmit path has stopped gracefully |
| arm_req_i | input | 1 | Request to arm (one-cycle write) |
| event_clr_i | input | 1 | Write-one-to-clear of the event bit |
| irq_en_i | input | 1 | Interrupt mask, 1 lets the event through |
| dlv_valid_o | output | 1 | Delivered byte valid |
| dlv_sof_o | output | 1 | Delivered start of frame |
| dlv_eof_o | output | 1 | Delivered end of frame |
| dlv_data_o | output | 8 | Delivered byte |
| armed_o | output | 1 | Enable bit, clears itself on detection |
| arm_rej_o | output | 1 | One-cycle pulse on a rejected arm request |
| event_o | output | 1 | Sticky wake event |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the block with SYNC_LEN=3, ADDR_REPS=3 and ADDR_BYTES=2, so a whole pattern is only nine bytes. With a pattern that short, the bench can corrupt every single pattern position in turn, and it can sweep the leading filler length before a good pattern. Short patterns also make the longer-sync, broken-sync and cross-frame cases cheap to write out byte by byte. All four combinations of the two stop inputs are tried against arming.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;

  typedef struct packed {
    logic       sof;
    logic       eof;
    logic [7:0] data;
  } mw_beat_t;
endpackage

// File: rtl/mw_arm_ctrl.sv
module mw_arm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_req_i,
  input  logic rx_stopped_i,
  input  logic tx_stopped_i,
  input  logic detect_i,
  input  logic event_clr_i,
  input  logic irq_en_i,
  output logic armed_o,
  output logic arm_rej_o,
  output logic event_o,
  output logic irq_o
);
  logic arm_ok;
  logic armed_q, rej_q, event_q;

  assign arm_ok = rx_stopped_i & tx_stopped_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      rej_q   <= 1'b0;
      event_q <= 1'b0;
    end else begin
      rej_q <= arm_req_i & ~arm_ok;
      if (detect_i)                armed_q <= 1'b0;
      else if (arm_req_i && arm_ok) armed_q <= 1'b1;
      // set wins over a simultaneous clear
      if (detect_i)         event_q <= 1'b1;
      else if (event_clr_i) event_q <= 1'b0;
    end
  end

  assign armed_o   = armed_q;
  assign arm_rej_o = rej_q;
  assign event_o   = event_q;
  assign irq_o     = event_q & irq_en_i;
endmodule

// File: rtl/mw_rx_gate.sv
module mw_rx_gate
  import mw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     armed_i,
  input  logic     vld_i,
  input  mw_beat_t beat_i,
  output logic     vld_o,
  output mw_beat_t beat_o
);
  logic drop_q, drop_cur;

  // a frame that began armed stays dropped to its end
  assign drop_cur = armed_i | (~beat_i.sof & drop_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    drop_q <= 1'b0;
    else if (vld_i) drop_q <= beat_i.eof ? 1'b0 : drop_cur;
  end

  assign vld_o       = vld_i & ~drop_cur;
  assign beat_o.sof  = beat_i.sof & vld_o;
  assign beat_o.eof  = beat_i.eof & vld_o;
  assign beat_o.data = beat_i.data;
endmodule

// File: rtl/mw_pattern_match.sv
module mw_pattern_match
  import mw_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int ADDR_REPS  = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    vld_i,
  input  mw_beat_t                beat_i,
  input  logic [8*ADDR_BYTES-1:0] addr_i,
  output logic                    detect_o
);
  localparam int TOTAL  = SYNC_LEN + ADDR_REPS * ADDR_BYTES;
  localparam int POS_W  = $clog2(TOTAL + 1);
  localparam int BIDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int FF_W   = $clog2(SYNC_LEN + 1);
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(TOTAL - 1);
  localparam logic [POS_W-1:0]  SYNC_POS  = POS_W'(SYNC_LEN);
  localparam logic [BIDX_W-1:0] LAST_BIDX = BIDX_W'(ADDR_BYTES - 1);
  localparam logic [FF_W-1:0]   FF_SAT    = FF_W'(SYNC_LEN);

  logic [7:0] addr_bytes [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_byte
    assign addr_bytes[g] = addr_i[8*(ADDR_BYTES-1-g) +: 8];
  end

  logic [POS_W-1:0]  pos_q, base_pos, pos_nxt;
  logic [BIDX_W-1:0] bidx_q, base_b, bidx_nxt;
  logic [FF_W-1:0]   ffrun_q, base_ff, ff_nxt;
  logic [7:0]        exp_byte;
  logic              hit, is_ff, in_sync;

  always_comb begin
    base_pos = beat_i.sof ? '0 : pos_q;
    base_b   = beat_i.sof ? '0 : bidx_q;
    base_ff  = beat_i.sof ? '0 : ffrun_q;
    in_sync  = base_pos < SYNC_POS;
    exp_byte = in_sync ? SYNC_BYTE : addr_bytes[base_b];
    hit      = beat_i.data == exp_byte;
    is_ff    = beat_i.data == SYNC_BYTE;
    ff_nxt   = is_ff ? ((base_ff == FF_SAT) ? FF_SAT : base_ff + 1'b1) : '0;
    if (hit) begin
      pos_nxt  = (base_pos == LAST_POS) ? '0 : base_pos + 1'b1;
      bidx_nxt = (in_sync || base_b == LAST_BIDX) ? '0 : base_b + 1'b1;
    end else begin
      // an all-ones break byte keeps the sync run it belongs to
      pos_nxt  = is_ff ? POS_W'(ff_nxt) : '0;
      bidx_nxt = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      bidx_q  <= '0;
      ffrun_q <= '0;
    end else if (!en_i) begin
      pos_q   <= '0;
      bidx_q  <= '0;
      ffrun_q <= '0;
    end else if (vld_i) begin
      pos_q   <= pos_nxt;
      bidx_q  <= bidx_nxt;
      ffrun_q <= ff_nxt;
    end
  end

  assign detect_o = en_i & vld_i & hit & (base_pos == LAST_POS);
endmodule

// File: rtl/magic_wake_det.sv
module magic_wake_det
  import mw_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int ADDR_REPS  = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_valid_i,
  input  logic                    rx_sof_i,
  input  logic                    rx_eof_i,
  input  logic [7:0]              rx_data_i,
  input  logic                    rx_enable_i,
  input  logic [8*ADDR_BYTES-1:0] station_addr_i,
  input  logic                    rx_stopped_i,
  input  logic                    tx_stopped_i,
  input  logic                    arm_req_i,
  input  logic                    event_clr_i,
  input  logic                    irq_en_i,
  output logic                    dlv_valid_o,
  output logic                    dlv_sof_o,
  output logic                    dlv_eof_o,
  output logic [7:0]              dlv_data_o,
  output logic                    armed_o,
  output logic                    arm_rej_o,
  output logic                    event_o,
  output logic                    irq_o
);
  mw_beat_t rx_beat, dlv_beat;
  logic     armed, detect, search_en;

  assign rx_beat.sof  = rx_sof_i;
  assign rx_beat.eof  = rx_eof_i;
  assign rx_beat.data = rx_data_i;
  assign search_en    = armed & rx_enable_i;

  mw_arm_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_req_i    (arm_req_i),
    .rx_stopped_i (rx_stopped_i),
    .tx_stopped_i (tx_stopped_i),
    .detect_i     (detect),
    .event_clr_i  (event_clr_i),
    .irq_en_i     (irq_en_i),
    .armed_o      (armed),
    .arm_rej_o    (arm_rej_o),
    .event_o      (event_o),
    .irq_o        (irq_o)
  );

  mw_pattern_match #(
    .SYNC_LEN   (SYNC_LEN),
    .ADDR_REPS  (ADDR_REPS),
    .ADDR_BYTES (ADDR_BYTES)
  ) i_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (search_en),
    .vld_i    (rx_valid_i),
    .beat_i   (rx_beat),
    .addr_i   (station_addr_i),
    .detect_o (detect)
  );

  mw_rx_gate i_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed),
    .vld_i   (rx_valid_i),
    .beat_i  (rx_beat),
    .vld_o   (dlv_valid_o),
    .beat_o  (dlv_beat)
  );

  assign dlv_sof_o  = dlv_beat.sof;
  assign dlv_eof_o  = dlv_beat.eof;
  assign dlv_data_o = dlv_beat.data;
  assign armed_o    = armed;
endmodule

// File: rtl/mw_checker.sv
module mw_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic rx_enable_i,
  input logic rx_stopped_i,
  input logic tx_stopped_i,
  input logic arm_req_i,
  input logic event_clr_i,
  input logic dlv_valid_o,
  input logic armed_o,
  input logic arm_rej_o,
  input logic event_o
);
  AST_ARM_NEEDS_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(arm_req_i && rx_stopped_i && tx_stopped_i)); // R2

  AST_REJ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_rej_o |-> $past(arm_req_i) && !$past(rx_stopped_i && tx_stopped_i)); // R2

  AST_NO_DLV_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> !dlv_valid_o); // R3

  AST_DETECT_NEEDS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_o) |-> $past(rx_enable_i && rx_valid_i)); // R5

  AST_DISARM_SETS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_o) |-> event_o); // R6

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !event_clr_i) |=> event_o); // R9
endmodule

bind magic_wake_det mw_checker i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .rx_enable_i  (rx_enable_i),
  .rx_stopped_i (rx_stopped_i),
  .tx_stopped_i (tx_stopped_i),
  .arm_req_i    (arm_req_i),
  .event_clr_i  (event_clr_i),
  .dlv_valid_o  (dlv_valid_o),
  .armed_o      (armed_o),
  .arm_rej_o    (arm_rej_o),
  .event_o      (event_o)
);

// File: tb/test_magic_wake_det.sv
module test_magic_wake_det;
  localparam int SL  = 3;
  localparam int RP  = 3;
  localparam int AB  = 2;
  localparam int TOT = SL + RP * AB;
  localparam logic [8*AB-1:0] ADDR = 16'h5AC3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_en = 1;
  logic [7:0] rx_data = '0;
  logic rx_st = 0, tx_st = 0, arm_req = 0, evt_clr = 0, irq_en = 0;
  logic dlv_valid, dlv_sof, dlv_eof, armed, arm_rej, evt, irq;
  logic [7:0] dlv_data;

  int checks = 0, failures = 0, dlv_cnt = 0;
  bit done = 0;
  logic [7:0] fr[$];

  always #10 clk = ~clk;

  magic_wake_det #(.SYNC_LEN(SL), .ADDR_REPS(RP), .ADDR_BYTES(AB)) i_magic_wake_det (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_data_i(rx_data), .rx_enable_i(rx_en),
    .station_addr_i(ADDR), .rx_stopped_i(rx_st), .tx_stopped_i(tx_st),
    .arm_req_i(arm_req), .event_clr_i(evt_clr), .irq_en_i(irq_en),
    .dlv_valid_o(dlv_valid), .dlv_sof_o(dlv_sof), .dlv_eof_o(dlv_eof),
    .dlv_data_o(dlv_data), .armed_o(armed), .arm_rej_o(arm_rej),
    .event_o(evt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic void add_sync(input int n);
    for (int i = 0; i < n; i++) fr.push_back(8'hFF);
  endfunction

  function automatic void add_addr(input int reps);
    for (int r = 0; r < reps; r++)
      for (int b = 0; b < AB; b++) fr.push_back(ADDR[8*(AB-1-b) +: 8]);
  endfunction

  function automatic void add_pattern();
    add_sync(SL);
    add_addr(RP);
  endfunction

  // drives fr as one frame, counts delivered bytes, returns to idle
  task automatic send_fr();
    dlv_cnt = 0;
    for (int i = 0; i < fr.size(); i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fr[i];
      rx_sof = (i == 0); rx_eof = (i == fr.size() - 1);
      #1;
      if (dlv_valid) dlv_cnt++;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    fr.delete();
  endtask

  task automatic do_arm(input logic rs, input logic ts);
    @(negedge clk);
    arm_req = 1; rx_st = rs; tx_st = ts;
    @(negedge clk);
    arm_req = 0; rx_st = 0; tx_st = 0;
  endtask

  task automatic clear_evt();
    @(negedge clk); evt_clr = 1;
    @(negedge clk); evt_clr = 0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 armed", armed, 0);
    chk("R1 rej", arm_rej, 0);
    chk("R1 event", evt, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: every stop combination
    for (int c = 0; c < 3; c++) begin
      do_arm(c[0], c[1]);
      chk("R2 rejected arm keeps armed low", armed, 0);
      chk("R2 reject pulse", arm_rej, 1);
      @(negedge clk);
      chk("R2 reject pulse one cycle", arm_rej, 0);
    end
    do_arm(1, 1);
    chk("R2 arm accepted", armed, 1);
    chk("R2 no reject", arm_rej, 0);

    // R5: no detection with reception disabled, still suppressed (R3)
    rx_en = 0;
    fr.push_back(8'h11); add_pattern(); send_fr();
    chk("R5 no detect when rx disabled", armed, 1);
    chk("R5 no event", evt, 0);
    chk("R3 armed frame suppressed", dlv_cnt, 0);
    rx_en = 1;

    // R4/R8: corrupt each pattern position in turn
    for (int p = 0; p < TOT; p++) begin
      fr.push_back(8'h11); add_pattern(); fr.push_back(8'h22);
      fr[p + 1] = 8'h00;
      send_fr();
      chk("R4 corrupted pattern not detected", armed, 1);
      chk("R4 corrupted pattern no event", evt, 0);
    end

    // R4/R6/R3/R9: leading filler sweep, good pattern, trailing bytes
    for (int j = 0; j < 6; j++) begin
      for (int k = 0; k < j; k++) fr.push_back(k[0] ? 8'hC3 : 8'h5A);
      add_pattern();
      fr.push_back(8'h33); fr.push_back(8'h44);
      irq_en = j[0];
      send_fr();
      chk("R6 disarm on detect", armed, 0);
      chk("R6 event on detect", evt, 1);
      chk("R9 irq follows mask", irq, j[0]);
      chk("R3 wake frame dropped to its end", dlv_cnt, 0);
      repeat (2) @(negedge clk);
      chk("R9 event sticky", evt, 1);
      irq_en = 1; #1;
      chk("R9 irq unmasked", irq, 1);
      clear_evt();
      chk("R9 event cleared", evt, 0);
      chk("R9 irq cleared", irq, 0);
      for (int k = 0; k < j + 3; k++) fr.push_back(8'hFF - k[7:0]);
      send_fr();
      chk("R3 disarmed frame delivered", dlv_cnt, j + 3);
      do_arm(1, 1);
    end

    // R8: sync run longer than SYNC_LEN
    add_sync(SL + 2); add_addr(RP); send_fr();
    chk("R8 long sync accepted", armed, 0);
    clear_evt(); do_arm(1, 1);

    // R8: 0xFF breaking an address run restarts sync
    add_pattern(); void'(fr.pop_back()); void'(fr.pop_back());
    void'(fr.pop_back()); void'(fr.pop_back());
    add_pattern(); send_fr();
    chk("R8 FF break restarts sync", armed, 0);
    chk("R8 FF break event", evt, 1);
    clear_evt(); do_arm(1, 1);

    // R8: non-FF break after a short resync does not match
    add_sync(SL); fr.push_back(8'h5A); add_sync(SL - 1); add_addr(RP); send_fr();
    chk("R8 short resync rejected", armed, 1);

    // R7: pattern split across frames
    fr.push_back(8'h11); add_sync(SL); add_addr(1); send_fr();
    add_addr(RP - 1); send_fr();
    chk("R7 split pattern not detected", armed, 1);
    chk("R7 split pattern no event", evt, 0);

    // R7: sof byte begins a fresh search
    add_sync(1); send_fr();
    add_pattern(); send_fr();
    chk("R7 pattern from sof detected", armed, 0);

    finish_run();
  end
endmodule